// File: doc/BRIEF.md
# Address-Seeded Line Scrambler and Self-Locking Descrambler

This block whitens a 100 Mbps code-group bit stream before line coding and restores it after reception. On the transmit side every valid bit is XORed with the next output bit of an 11-bit pseudo-random generator, which breaks up long repetitive patterns and so lowers peaks in the radiated spectrum. The transmit generator's starting state is built from the port's 5-bit management address whenever reset is held, so ports sharing a cable bundle run different sequences.

The receive side uses a generator with the same recurrence. It has no seed of its own: while unlocked it assumes the line is idle (data all ones), recovers generator bits straight from the line and declares lock once its predictions agree with the line for a run of bits. After lock it runs freely and descrambles. A supervision counter drops lock when too few ones come out of the descrambler within a window, and the hunt then starts over.

Top module: `phy_scrambler`

## Requirements
- R1: The generator key bit is k = s[10] ^ s[8] of the 11-bit state s, and on each valid bit the state becomes {s[9:0], k}; tx_out_bit equals tx_bit ^ k, registered one clock after the input is presented.
- R2: While rst_n is low at a clock edge the transmit state is loaded with s[4:0] = phy_addr and s[10:5] = all ones.
- R3: The transmit state advances only on clocks where tx_valid is high; on other clocks the sequence pauses and resumes where it stopped.
- R4: tx_out_valid and rx_out_valid each equal their input valid delayed by one clock, and are low after reset.
- R5: rx_locked is low after reset and rises only after LOCK_RUN consecutive valid idle bits whose recovered key matches the prediction; it is never high after fewer than LOCK_RUN valid bits and is always high after 11 + LOCK_RUN valid idle bits.
- R6: Once locked, rx_out_bit equals the transmitted data bit (rx_bit ^ k) one clock after the received bit.
- R7: While locked, if fewer than SUP_MIN ones are descrambled within a window of SUP_WIN valid bits, rx_locked falls at the window's end and hunting restarts; steady idle keeps lock.
- R8: The receive state, lock state and counters change only on clocks where rx_valid is high.
- R9: The transmit generator state is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset, loads the transmit seed |
| phy_addr | input | 5 | Port management address used as seed |
| tx_valid | input | 1 | Transmit bit strobe |
| tx_bit | input | 1 | Transmit code bit |
| tx_out_valid | output | 1 | Scrambled bit strobe |
| tx_out_bit | output | 1 | Scrambled bit |
| rx_valid | input | 1 | Receive bit strobe |
| rx_bit | input | 1 | Received scrambled bit |
| rx_out_valid | output | 1 | Descrambled bit strobe |
| rx_out_bit | output | 1 | Descrambled bit |
| rx_locked | output | 1 | Descrambler synchronised |

## Verification
The bench walks a table of addresses and data words with strobe gaps, so a seed wired in the wrong bit order, a constant seed or a generator that steps on idle strobes shows up as a wrong scrambled bit within the first few outputs. On the receive side it checks lock neither too early, which would catch a run counter that ignores mismatches, nor too late after the eleven-bit fill. A sustained burst of zero data must drop lock while long idle must keep it, exposing an inverted or missing supervision test, and relock afterwards must follow the same timing.

// File: rtl/phy_scrambler.sv
module phy_scrambler #(
  parameter int LOCK_RUN = 32,
  parameter int SUP_WIN  = 64,
  parameter int SUP_MIN  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] phy_addr,
  input  logic       tx_valid,
  input  logic       tx_bit,
  output logic       tx_out_valid,
  output logic       tx_out_bit,
  input  logic       rx_valid,
  input  logic       rx_bit,
  output logic       rx_out_valid,
  output logic       rx_out_bit,
  output logic       rx_locked
);
  localparam int SW = 11;
  localparam int RW = $clog2(LOCK_RUN + 1);
  localparam int WW = $clog2(SUP_WIN + 1);

  logic [SW-1:0] tx_lfsr, rx_lfsr;
  logic          tx_key, rx_key, rx_match, rx_data;
  logic [RW-1:0] run;
  logic [WW-1:0] win, ones, ones_next;

  assign tx_key    = tx_lfsr[10] ^ tx_lfsr[8];
  assign rx_key    = rx_lfsr[10] ^ rx_lfsr[8];
  assign rx_data   = rx_bit ^ rx_key;
  assign rx_match  = rx_bit != rx_key;
  assign ones_next = ones + WW'(rx_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_lfsr      <= {6'h3f, phy_addr};
      tx_out_valid <= 1'b0;
      tx_out_bit   <= 1'b0;
    end else begin
      tx_out_valid <= tx_valid;
      if (tx_valid) begin
        tx_out_bit <= tx_bit ^ tx_key;
        tx_lfsr    <= {tx_lfsr[SW-2:0], tx_key};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_lfsr      <= '1;
      rx_locked    <= 1'b0;
      run          <= '0;
      win          <= '0;
      ones         <= '0;
      rx_out_valid <= 1'b0;
      rx_out_bit   <= 1'b0;
    end else begin
      rx_out_valid <= rx_valid;
      if (rx_valid) begin
        rx_out_bit <= rx_data;
        if (!rx_locked) begin
          rx_lfsr <= {rx_lfsr[SW-2:0], ~rx_bit};
          win     <= '0;
          ones    <= '0;
          if (!rx_match)
            run <= '0;
          else if (run == RW'(LOCK_RUN - 1)) begin
            run       <= '0;
            rx_locked <= 1'b1;
          end else
            run <= run + 1'b1;
        end else begin
          rx_lfsr <= {rx_lfsr[SW-2:0], rx_key};
          if (win == WW'(SUP_WIN - 1)) begin
            win  <= '0;
            ones <= '0;
            if (ones_next < WW'(SUP_MIN)) rx_locked <= 1'b0;
          end else begin
            win  <= win + 1'b1;
            ones <= ones_next;
          end
        end
      end
    end
  end
endmodule

module phy_scrambler_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  phy_addr,
  input logic        tx_valid,
  input logic        tx_out_valid,
  input logic        rx_valid,
  input logic        rx_out_valid,
  input logic        rx_locked,
  input logic [10:0] tx_lfsr,
  input logic [10:0] rx_lfsr
);
  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  a_r2_seed_load: assert property (@(posedge clk)
    !rst_n |=> tx_lfsr == {6'h3f, $past(phy_addr)});

  a_r3_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !tx_valid) |=> $stable(tx_lfsr));

  a_r4_tx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> tx_out_valid == $past(tx_valid));

  a_r4_rx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> rx_out_valid == $past(rx_valid));

  a_r8_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !rx_valid) |=> ($stable(rx_lfsr) && $stable(rx_locked)));

  a_r9_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> tx_lfsr != '0);
endmodule

bind phy_scrambler phy_scrambler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phy_addr(phy_addr),
  .tx_valid(tx_valid), .tx_out_valid(tx_out_valid),
  .rx_valid(rx_valid), .rx_out_valid(rx_out_valid),
  .rx_locked(rx_locked), .tx_lfsr(tx_lfsr), .rx_lfsr(rx_lfsr)
);

// File: tb/tb_phy_scrambler.sv
`timescale 1ns/1ps
module tb_phy_scrambler;
  localparam int LOCK_RUN = 32;
  localparam int SUP_WIN  = 64;
  localparam int SUP_MIN  = 8;

  // {addr[4:0], data[15:0]} : seed (R2) and scramble (R1) vectors
  localparam logic [20:0] VEC [8] = '{
    {5'd0,  16'h0000}, {5'd31, 16'h0000}, {5'd1,  16'hFFFF}, {5'd17, 16'hA5A5},
    {5'd10, 16'h1234}, {5'd21, 16'hFEDC}, {5'd5,  16'h8001}, {5'd30, 16'h7FFE}
  };

  logic clk = 0, rst_n = 0;
  logic [4:0] phy_addr = 0;
  logic tx_valid = 0, tx_bit = 0, rx_valid = 0, rx_bit = 0;
  logic tx_out_valid, tx_out_bit, rx_out_valid, rx_out_bit, rx_locked;
  int checks = 0, fails = 0;
  logic [10:0] m_tx, m_rx;

  always #2.5 clk = ~clk;

  phy_scrambler #(.LOCK_RUN(LOCK_RUN), .SUP_WIN(SUP_WIN), .SUP_MIN(SUP_MIN)) dut (
    .clk(clk), .rst_n(rst_n), .phy_addr(phy_addr),
    .tx_valid(tx_valid), .tx_bit(tx_bit),
    .tx_out_valid(tx_out_valid), .tx_out_bit(tx_out_bit),
    .rx_valid(rx_valid), .rx_bit(rx_bit),
    .rx_out_valid(rx_out_valid), .rx_out_bit(rx_out_bit), .rx_locked(rx_locked));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic tv, input logic tb_, input logic rv, input logic rb);
    tx_valid = tv; tx_bit = tb_; rx_valid = rv; rx_bit = rb;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [4:0] a);
    rst_n = 0; phy_addr = a;
    tick(0, 0, 0, 0); tick(0, 0, 0, 0);
    rst_n = 1;
    m_tx = {6'h3f, a};
  endtask

  function automatic logic next_key(inout logic [10:0] s);
    logic k;
    k = s[10] ^ s[8];
    s = {s[9:0], k};
    return k;
  endfunction

  // send one received bit carrying data d; gap cycle first when requested
  task automatic rx_send(input logic d, input logic gap);
    logic k;
    if (gap) begin
      tick(0, 0, 0, 0);
      chk(rx_out_valid == 0, "R8 rx gap strobe", rx_out_valid, 0);
    end
    k = next_key(m_rx);
    tick(0, 0, 1, d ^ k);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int vcnt;
    @(negedge clk);
    do_reset(5'd3);
    chk(tx_out_valid == 0, "R4 reset tx strobe", tx_out_valid, 0);
    chk(rx_out_valid == 0, "R4 reset rx strobe", rx_out_valid, 0);
    chk(rx_locked == 0, "R5 reset unlocked", rx_locked, 0);

    // R1 R2 R3 R4: table walk
    foreach (VEC[v]) begin
      int idx;
      do_reset(VEC[v][20:16]);
      idx = 0;
      for (int i = 0; idx < 16; i++) begin
        if (i % 5 == 4) begin
          tick(0, 0, 0, 0);
          chk(tx_out_valid == 0, "R3 tx gap strobe", tx_out_valid, 0);
        end else begin
          logic d, k, e;
          d = VEC[v][15 - idx];
          k = next_key(m_tx);
          e = d ^ k;
          tick(1, d, 0, 0);
          chk(tx_out_valid == 1, "R4 tx strobe", tx_out_valid, 1);
          chk(tx_out_bit == e, "R1 R2 scrambled bit", tx_out_bit, e);
          idx++;
        end
      end
    end

    // Receive side
    do_reset(5'd9);
    m_rx = 11'h5A3;
    vcnt = 0;
    for (int i = 0; i < LOCK_RUN - 1; i++) begin rx_send(1, i % 4 == 3); vcnt++; end
    chk(rx_locked == 0, "R5 no early lock", rx_locked, 0);
    for (int i = vcnt; i < LOCK_RUN + 11; i++) rx_send(1, i % 4 == 3);
    chk(rx_locked == 1, "R5 locked on idle", rx_locked, 1);

    for (int i = 0; i < 40; i++) begin
      logic d;
      d = ((i * 7) % 3) == 0;
      rx_send(d, i % 6 == 5);
      chk(rx_out_valid == 1 && rx_out_bit == d, "R6 descrambled bit", rx_out_bit, d);
    end

    for (int i = 0; i < 3 * SUP_WIN; i++) rx_send(1, 0);
    chk(rx_locked == 1, "R7 idle keeps lock", rx_locked, 1);

    for (int i = 0; i < 2 * SUP_WIN; i++) rx_send(0, 0);
    chk(rx_locked == 0, "R7 lock lost on zeros", rx_locked, 0);

    // R8: idle strobes only, lock state must not move
    for (int i = 0; i < 50; i++) tick(0, 0, 0, 1);
    chk(rx_locked == 0, "R8 no relock without strobe", rx_locked, 0);

    for (int i = 0; i < LOCK_RUN + 11; i++) rx_send(1, 0);
    chk(rx_locked == 1, "R7 relock after loss", rx_locked, 1);
    rx_send(0, 0);
    chk(rx_out_bit == 0, "R6 data after relock", rx_out_bit, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule